// File: doc/BRIEF.md
# MSI Message Generator with Per-Vector Masking

This block turns interrupt requests from a device into single-beat memory-write messages for message-signalled interrupts. It reads its settings as plain inputs from the capability registers: the global enable, the multiple-message-enable field, the 32-bit or 64-bit message address, the 16-bit message data and the per-vector mask. It then forms one address/data pair per delivered interrupt. The vector number is folded into the low bits of the data word. The number of low bits replaced is set by the multiple-message-enable field.

A request for a masked vector does not produce a message. Instead, the vector's pending bit is set in a register that the block owns. When software clears a mask bit, the surrounding logic issues a replay for that vector. The block then sends the held message and clears the pending bit. Only one message is held at a time. Both request ports stall until the bus side accepts the message, and a replay is served before a new request.

Top module: `msi_gen`

## Requirements
- R1: After reset, `msg_valid`, `msi_err` and every `pending` bit are 0.
- R2: An accepted request with `req_level` = 0 produces no message and leaves `pending` unchanged.
- R3: An accepted request with level 1 for a vector whose `cfg_mask` bit is 1 (masking implemented, block enabled) sets that vector's `pending` bit in the next cycle and produces no message.
- R4: A sent message's address is {`cfg_addr_hi`, `cfg_addr_lo`} when `cfg_is64` = 1, and `cfg_addr_lo` zero-extended to 64 bits otherwise.
- R5: A sent message's data has bits 31:16 zero. Its bits 15:0 are `cfg_data` with the low `cfg_mme` bits (the 3-bit field, a value n keeps 2^n vectors) replaced by the same low bits of the vector number.
- R6: Sending a message for a vector clears that vector's `pending` bit in the same edge that loads the message.
- R7: With `cfg_mask_en` = 0, the `cfg_mask` input has no effect: every enabled level-1 request is sent, and `pending` is held at all zeros.
- R8: A request or replay accepted while `cfg_msi_en` = 0 is dropped with no message and no pending change. `msi_err` is 1 for exactly the next cycle.
- R9: While `msg_valid` = 1, both `req_ready` and `replay_ready` are 0. `msg_addr` and `msg_data` stay stable until `msg_ready` = 1.
- R10: `req_ready` is 0 whenever `replay_valid` = 1. An accepted replay for an unmasked vector whose `pending` bit is 1 sends that vector's message. A replay for a vector whose `pending` bit is 0 is ignored.
- R11: A replay for a vector that is still masked leaves its `pending` bit at 1 and produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msi_en | input | 1 | Global enable for message interrupts |
| cfg_mme | input | 3 | Multiple-message-enable field (log2 of enabled vectors) |
| cfg_is64 | input | 1 | Use the 64-bit address form |
| cfg_mask_en | input | 1 | Per-vector masking is implemented |
| cfg_addr_lo | input | 32 | Low address word |
| cfg_addr_hi | input | 32 | High address word |
| cfg_data | input | 16 | Message data template |
| cfg_mask | input | NUM_VEC | Per-vector mask bits |
| req_valid | input | 1 | New interrupt request |
| req_vec | input | VEC_W | Vector of the new request |
| req_level | input | 1 | 1 = assert, 0 = deassert (ignored) |
| req_ready | output | 1 | New request accepted this cycle |
| replay_valid | input | 1 | Replay request for an unmasked vector |
| replay_vec | input | VEC_W | Vector to replay |
| replay_ready | output | 1 | Replay accepted this cycle |
| msg_valid | output | 1 | Message held for the bus |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_ready | input | 1 | Bus accepts the message |
| pending | output | NUM_VEC | Pending bits of masked vectors |
| msi_err | output | 1 | One-cycle flag: request dropped while disabled |

## Verification
The assertions check the handshake rules on every cycle: the stall while a message is held, a held message staying stable, a replay blocking new requests, the upper data half being zero, and the pending register being cleared when masking is absent. They also check the one-step results of an accepted request: a masked request setting its pending bit, a deasserting request changing nothing, and a disabled request raising the error flag. Only the bench's scenarios show the address and data values. These cover the data encoding under different multiple-message-enable values, the 32/64-bit address choice, and the full mask, replay and send sequence that clears a pending bit.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msi_msg_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_REQ    = 2'd1,
        SRC_REPLAY = 2'd2
    } msi_src_e;

    // Low-bit field width selected by the multiple-message-enable value.
    function automatic logic [15:0] vec_field_mask(input logic [2:0] mme);
        return (16'd1 << mme) - 16'd1;
    endfunction

    function automatic logic [31:0] encode_data(input logic [15:0] tmpl,
                                                input logic [15:0] vec,
                                                input logic [2:0]  mme);
        logic [15:0] m;
        m = vec_field_mask(mme);
        return {16'h0000, (tmpl & ~m) | (vec & m)};
    endfunction

endpackage

// File: rtl/msi_vec_arb.sv
module msi_vec_arb
    import msi_gen_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             busy,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             req_level,
    input  logic             replay_valid,
    input  logic [VEC_W-1:0] replay_vec,
    output logic             req_ready,
    output logic             replay_ready,
    output logic             sel_fire,
    output msi_src_e         sel_src,
    output logic [VEC_W-1:0] sel_vec,
    output logic             sel_level
);
    always_comb begin
        replay_ready = !busy;
        req_ready    = !busy && !replay_valid;
        sel_fire     = 1'b0;
        sel_src      = SRC_NONE;
        sel_vec      = req_vec;
        sel_level    = req_level;
        if (replay_valid && replay_ready) begin
            sel_fire  = 1'b1;
            sel_src   = SRC_REPLAY;
            sel_vec   = replay_vec;
            sel_level = 1'b1;
        end else if (req_valid && req_ready) begin
            sel_fire  = 1'b1;
            sel_src   = SRC_REQ;
        end
    end
endmodule

// File: rtl/msi_pend_reg.sv
module msi_pend_reg #(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mask_en,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [VEC_W-1:0]   vec,
    output logic [NUM_VEC-1:0] pending
);
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
        logic hit;
        assign hit = (vec == VEC_W'(i));
        always_ff @(posedge clk) begin
            if (rst || !mask_en)
                pending[i] <= 1'b0;
            else if (set_en && hit)
                pending[i] <= 1'b1;
            else if (clr_en && hit)
                pending[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
    import msi_gen_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             is64,
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    input  logic [15:0]      tmpl,
    input  logic [2:0]       mme,
    input  logic [VEC_W-1:0] vec,
    output msi_msg_t         msg
);
    always_comb begin
        msg.addr = is64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
        msg.data = encode_data(tmpl, 16'(vec), mme);
    end
endmodule

// File: rtl/msi_gen.sv
module msi_gen
    import msi_gen_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_msi_en,
    input  logic [2:0]         cfg_mme,
    input  logic               cfg_is64,
    input  logic               cfg_mask_en,
    input  logic [31:0]        cfg_addr_lo,
    input  logic [31:0]        cfg_addr_hi,
    input  logic [15:0]        cfg_data,
    input  logic [NUM_VEC-1:0] cfg_mask,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic               req_level,
    output logic               req_ready,
    input  logic               replay_valid,
    input  logic [VEC_W-1:0]   replay_vec,
    output logic               replay_ready,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    input  logic               msg_ready,
    output logic [NUM_VEC-1:0] pending,
    output logic               msi_err
);
    logic             sel_fire;
    msi_src_e         sel_src;
    logic [VEC_W-1:0] sel_vec;
    logic             sel_level;
    msi_msg_t         fmt_msg;
    msi_msg_t         msg_q;
    logic             valid_q;
    logic             err_q;
    logic             active;
    logic             masked;
    logic             set_pend;
    logic             do_send;

    msi_vec_arb #(.VEC_W(VEC_W)) u_arb (
        .busy         (valid_q),
        .req_valid    (req_valid),
        .req_vec      (req_vec),
        .req_level    (req_level),
        .replay_valid (replay_valid),
        .replay_vec   (replay_vec),
        .req_ready    (req_ready),
        .replay_ready (replay_ready),
        .sel_fire     (sel_fire),
        .sel_src      (sel_src),
        .sel_vec      (sel_vec),
        .sel_level    (sel_level)
    );

    msi_msg_fmt #(.VEC_W(VEC_W)) u_fmt (
        .is64    (cfg_is64),
        .addr_lo (cfg_addr_lo),
        .addr_hi (cfg_addr_hi),
        .tmpl    (cfg_data),
        .mme     (cfg_mme),
        .vec     (sel_vec),
        .msg     (fmt_msg)
    );

    always_comb begin
        active   = sel_fire && cfg_msi_en && sel_level;
        masked   = cfg_mask_en && cfg_mask[sel_vec];
        set_pend = active && masked;
        do_send  = active && !masked &&
                   ((sel_src == SRC_REQ) || pending[sel_vec]);
    end

    msi_pend_reg #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .mask_en (cfg_mask_en),
        .set_en  (set_pend),
        .clr_en  (do_send),
        .vec     (sel_vec),
        .pending (pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= sel_fire && !cfg_msi_en;
            if (do_send) begin
                valid_q <= 1'b1;
                msg_q   <= fmt_msg;
            end else if (valid_q && msg_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = msg_q.addr;
    assign msg_data  = msg_q.data;
    assign msi_err   = err_q;

endmodule

// File: rtl/msi_gen_chk.sv
module msi_gen_chk #(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_msi_en,
    input logic               cfg_mask_en,
    input logic [NUM_VEC-1:0] cfg_mask,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vec,
    input logic               req_level,
    input logic               req_ready,
    input logic               replay_valid,
    input logic               replay_ready,
    input logic               msg_valid,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               msg_ready,
    input logic [NUM_VEC-1:0] pending,
    input logic               msi_err
);
    logic             acc_req;
    logic             acc_rep;
    logic [VEC_W-1:0] vec_q;

    assign acc_req = req_valid && req_ready;
    assign acc_rep = replay_valid && replay_ready;

    always_ff @(posedge clk) vec_q <= req_vec;

    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (!req_ready && !replay_ready)); // R9

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R9

    AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (rst)
        replay_valid |-> !req_ready); // R10

    AST_MASK_PEND: assert property (@(posedge clk) disable iff (rst)
        (acc_req && cfg_msi_en && req_level && cfg_mask_en && cfg_mask[req_vec])
        |=> (pending[vec_q] && !msg_valid)); // R3

    AST_LOW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !req_level && cfg_mask_en) |=> (!msg_valid && $stable(pending))); // R2

    AST_DIS_DROP: assert property (@(posedge clk) disable iff (rst)
        ((acc_req || acc_rep) && !cfg_msi_en) |=> (msi_err && !msg_valid)); // R8

    AST_NOMASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !cfg_mask_en |=> (pending == '0)); // R7

    AST_DATA_UPPER: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_data[31:16] == 16'h0000)); // R5

endmodule

bind msi_gen msi_gen_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_msi_en   (cfg_msi_en),
    .cfg_mask_en  (cfg_mask_en),
    .cfg_mask     (cfg_mask),
    .req_valid    (req_valid),
    .req_vec      (req_vec),
    .req_level    (req_level),
    .req_ready    (req_ready),
    .replay_valid (replay_valid),
    .replay_ready (replay_ready),
    .msg_valid    (msg_valid),
    .msg_addr     (msg_addr),
    .msg_data     (msg_data),
    .msg_ready    (msg_ready),
    .pending      (pending),
    .msi_err      (msi_err)
);

// File: tb/tb_msi_gen.sv
module tb_msi_gen;
    localparam int NV = 32;
    localparam int VW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_msi_en = 1'b0;
    logic [2:0]    cfg_mme = 3'd0;
    logic          cfg_is64 = 1'b0;
    logic          cfg_mask_en = 1'b1;
    logic [31:0]   cfg_addr_lo = 32'hFEE0_1000;
    logic [31:0]   cfg_addr_hi = 32'h0000_00AB;
    logic [15:0]   cfg_data = 16'h1230;
    logic [NV-1:0] cfg_mask = '0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vec = '0;
    logic          req_level = 1'b1;
    logic          req_ready;
    logic          replay_valid = 1'b0;
    logic [VW-1:0] replay_vec = '0;
    logic          replay_ready;
    logic          msg_valid;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic          msg_ready = 1'b1;
    logic [NV-1:0] pending;
    logic          msi_err;

    always #2.5 clk = ~clk;

    msi_gen #(.NUM_VEC(NV)) dut (.*);

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Behavioural reference model
    bit          m_valid;
    bit [63:0]   m_addr;
    bit [31:0]   m_data;
    bit [NV-1:0] m_pend;
    bit          m_err;

    always @(posedge clk) begin
        bit busy, fired, isrep, lvl;
        int v, keep;
        if (rst) begin
            m_valid = 0; m_addr = 0; m_data = 0; m_pend = 0; m_err = 0;
        end else begin
            busy = m_valid; fired = 0; isrep = 0; lvl = 0; v = 0;
            if (!busy && replay_valid) begin
                fired = 1; isrep = 1; v = int'(replay_vec); lvl = 1;
            end else if (!busy && req_valid) begin
                fired = 1; v = int'(req_vec); lvl = req_level;
            end
            m_err = fired && !cfg_msi_en;
            if (busy && msg_ready) m_valid = 0;
            if (fired && cfg_msi_en && lvl) begin
                if (cfg_mask_en && cfg_mask[v]) m_pend[v] = 1;
                else if (!isrep || m_pend[v]) begin
                    keep = (1 << int'(cfg_mme)) - 1;
                    m_valid = 1;
                    m_addr = cfg_is64 ? {cfg_addr_hi, cfg_addr_lo} : {32'h0, cfg_addr_lo};
                    m_data = 32'((int'(cfg_data) & ~keep) | (v & keep)) & 32'h0000_FFFF;
                    m_pend[v] = 0;
                end
            end
            if (!cfg_mask_en) m_pend = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(msg_valid === m_valid, "R9 msg_valid", 64'(msg_valid), 64'(m_valid));
        if (m_valid) begin
            chk(msg_addr === m_addr, "R4 msg_addr", msg_addr, m_addr);
            chk(msg_data === m_data, "R5 msg_data", 64'(msg_data), 64'(m_data));
        end
        chk(pending === m_pend, "R3/R6 pending", 64'(pending), 64'(m_pend));
        chk(msi_err === m_err, "R8 msi_err", 64'(msi_err), 64'(m_err));
        chk(req_ready === (!m_valid && !replay_valid), "R10 req_ready",
            64'(req_ready), 64'(!m_valid && !replay_valid));
        chk(replay_ready === !m_valid, "R9 replay_ready", 64'(replay_ready), 64'(!m_valid));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
    endtask

    // Offer one request (rep=0) or replay (rep=1) until it is accepted.
    task automatic offer(input bit rep, input int v, input bit lvl);
        if (rep) begin replay_valid = 1; replay_vec = VW'(v); end
        else begin req_valid = 1; req_vec = VW'(v); req_level = lvl; end
        #0.5;
        while (!(rep ? replay_ready : req_ready)) tick();
        tick();
        replay_valid = 0; req_valid = 0; req_level = 1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 0;
        tick();
        // R1: reset state
        chk(msg_valid === 0 && pending === '0 && msi_err === 0, "R1 reset state",
            {pending, 30'h0, msg_valid, msi_err}, 64'h0);

        cfg_msi_en = 1;
        // R5 with mme=0: data unchanged; R4 32-bit address
        offer(0, 3, 1);
        chk(msg_data === 32'h0000_1230, "R5 mme0 data", 64'(msg_data), 64'h1230);
        chk(msg_addr === 64'h0000_0000_FEE0_1000, "R4 32-bit addr", msg_addr, 64'hFEE0_1000);
        tick();

        // R5 with mme=3: low three bits from vector 5
        cfg_mme = 3'd3;
        offer(0, 5, 1);
        chk(msg_data === 32'h0000_1235, "R5 mme3 data", 64'(msg_data), 64'h1235);
        tick();

        // R4 64-bit address
        cfg_is64 = 1; cfg_mme = 3'd5;
        offer(0, 22, 1);
        chk(msg_addr === 64'h0000_00AB_FEE0_1000, "R4 64-bit addr", msg_addr, 64'hAB_FEE0_1000);
        chk(msg_data === 32'h0000_1236, "R5 mme5 data", 64'(msg_data), 64'h1236);
        tick();

        // R3: masked request sets pending, no message
        cfg_mask[7] = 1;
        offer(0, 7, 1);
        chk(pending[7] === 1 && msg_valid === 0, "R3 masked pends", 64'(pending), 64'h80);

        // R2: deasserting request ignored
        offer(0, 9, 0);
        chk(msg_valid === 0 && pending === 32'h80, "R2 level low ignored", 64'(pending), 64'h80);

        // R11: replay while still masked keeps pending
        offer(1, 7, 1);
        chk(msg_valid === 0 && pending[7] === 1, "R11 replay masked", 64'(pending), 64'h80);

        // R10/R6: unmask, replay competes with new request and wins
        cfg_mask[7] = 0;
        req_valid = 1; req_vec = VW'(12); req_level = 1;
        replay_valid = 1; replay_vec = VW'(7);
        #0.5;
        chk(req_ready === 0, "R10 replay blocks request", 64'(req_ready), 64'h0);
        tick();
        replay_valid = 0;
        chk(msg_valid === 1 && msg_data[4:0] === 5'd7, "R10 replay sent", 64'(msg_data), 64'h7);
        chk(pending[7] === 0, "R6 pending cleared", 64'(pending), 64'h0);
        tick(); tick();
        req_valid = 0;
        tick();

        // R10: replay of a non-pending vector ignored
        offer(1, 9, 1);
        chk(msg_valid === 0, "R10 replay not pending", 64'(msg_valid), 64'h0);

        // R9: backpressure holds message and stalls requests
        msg_ready = 0;
        offer(0, 1, 1);
        req_valid = 1; req_vec = VW'(2);
        for (int i = 0; i < 4; i++) begin
            #0.5;
            chk(req_ready === 0 && msg_valid === 1, "R9 stall", 64'(req_ready), 64'h0);
            tick();
        end
        msg_ready = 1;
        while (!req_ready) tick();
        tick();
        req_valid = 0;
        tick(); tick();

        // R8: disabled drops with one-cycle error
        cfg_msi_en = 0;
        offer(0, 4, 1);
        chk(msi_err === 1 && msg_valid === 0, "R8 err flag", 64'(msi_err), 64'h1);
        tick();
        chk(msi_err === 0, "R8 err one cycle", 64'(msi_err), 64'h0);
        cfg_msi_en = 1;

        // R7: masking absent, mask ignored
        cfg_mask = '1;
        offer(0, 6, 1);
        chk(pending[6] === 1, "R3 pend before R7", 64'(pending), 64'h40);
        cfg_mask_en = 0;
        tick();
        offer(0, 8, 1);
        chk(msg_valid === 1 && pending === '0, "R7 mask ignored", 64'(pending), 64'h0);
        tick(); tick();

        finish_run();
    end
endmodule